// File: doc/BRIEF.md
# Sparse Ling Parallel-Prefix Adder

This block is a purely combinational two-operand binary adder. It takes two operands and a carry-in, and it returns the sum and the carry-out. The result matches the arithmetic value a + b + cin exactly. The width is a parameter: it defaults to 16 and can be set to 32 or to any other power of two of at least 4.

Each bit forms a generate term (AND) and a transmit term (OR). Adjacent bits are paired, and each pair feeds a radix-2 prefix tree with sparseness 2. Because of this, pseudo-carries are computed only at odd bit positions, which is one per pair. A pseudo-carry is a reduced carry: the true carry out of bit i is t_i AND H_i.

Both sum bits of a pair are computed ahead of time for each value of the pseudo-carry that enters the pair. That pseudo-carry then picks the right candidate through a multiplexer. The carry-in enters as the pseudo-carry below bit 0, with its transmit term held at 1.

Top module: `ling_sparse_adder`

## Requirements
- R1: For every input, `sum` equals the low W bits of a + b + cin.
- R2: For every input, `cout` equals bit W of a + b + cin.
- R3: With `a` all ones, `b` zero and `cin` = 1, the carry runs through every position. The result is `sum` = 0 and `cout` = 1.
- R4: With `b` zero and `cin` = 0, `sum` equals `a` and `cout` is 0.
- R5: When the top bit is 0 in both operands, `cout` is 0.
- R6: When both operands are all ones, `cout` is 1. Bit 0 of `sum` equals `cin`, and every other bit of `sum` is 1.
- R7: The width parameter W accepts any power of two of at least 4, for example 8, 16 or 32, and R1 and R2 hold at each of them. The default is 16.
- R8: With the alternating operands a = 0101...01 and b = 1010...10:
  - `cin` = 0 gives an all-ones `sum` and `cout` = 0.
  - `cin` = 1 gives `sum` = 0 and `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the sum |
| cout | output | 1 | Carry out of the top bit |

## Verification
The embedded assertions assume that the inputs are two-state and have settled when the outputs are evaluated. They hold for any such value, since the block has no state and no forbidden input. The stimulus only ever applies fully driven vectors, and it waits between a change and the matching sample.

The bench covers every operand pair and carry-in at a width of 8. At widths 16 and 32 it applies seeded random vectors plus the named corner patterns.

// File: rtl/ling_sparse_adder.sv
module ling_sparse_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int M = W / 2;
  localparam int L = $clog2(M);

  logic [W-1:0] g, t, p;
  assign g = a & b;
  assign t = a | b;
  assign p = a ^ b;

  logic [M-1:0] gg [L+1];
  logic [M-1:0] pp [L+1];

  genvar k, l;
  generate
    for (k = 0; k < M; k++) begin : pair_leaf
      if (k == 0) begin : base
        assign gg[0][0] = g[1] | g[0] | (t[0] & cin);
        assign pp[0][0] = 1'b0;
      end else begin : mid
        assign gg[0][k] = g[2*k+1] | g[2*k];
        assign pp[0][k] = t[2*k] & t[2*k-1];
      end
    end

    for (l = 0; l < L; l++) begin : tree_lvl
      for (k = 0; k < M; k++) begin : node
        if (k >= (1 << l)) begin : merge
          assign gg[l+1][k] = gg[l][k] | (pp[l][k] & gg[l][k-(1<<l)]);
          assign pp[l+1][k] = pp[l][k] & pp[l][k-(1<<l)];
        end else begin : pass
          assign gg[l+1][k] = gg[l][k];
          assign pp[l+1][k] = pp[l][k];
        end
      end
    end

    for (k = 0; k < M; k++) begin : sum_sel
      logic hin, tin;
      logic ev0, ev1, od0, od1;
      if (k == 0) begin : first
        assign hin = cin;
        assign tin = 1'b1;
      end else begin : rest
        assign hin = gg[L][k-1];
        assign tin = t[2*k-1];
      end
      assign ev0 = p[2*k];
      assign ev1 = p[2*k] ^ tin;
      assign od0 = p[2*k+1] ^ g[2*k];
      assign od1 = p[2*k+1] ^ (g[2*k] | (t[2*k] & tin));
      assign sum[2*k]   = hin ? ev1 : ev0;
      assign sum[2*k+1] = hin ? od1 : od0;
    end
  endgenerate

  assign cout = t[W-1] & gg[L][M-1];

  always_comb begin
    // R1 R2
    exact_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("exact_sum_chk");
    // R5
    top_clear_chk: assert (!(!a[W-1] && !b[W-1] && cout))
      else $error("top_clear_chk");
    // R4
    zero_operand_chk: assert (!(b == '0 && !cin) || (sum == a && !cout))
      else $error("zero_operand_chk");
    // R6
    all_ones_chk: assert (!(a == '1 && b == '1) || (cout && sum == {{(W-1){1'b1}}, cin}))
      else $error("all_ones_chk");
  end
endmodule

// File: tb/ling_sparse_adder_tb_top.sv
module ling_sparse_adder_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [15:0] a16, b16, s16;  logic c16, co16;
  logic [7:0]  a8,  b8,  s8;   logic c8,  co8;
  logic [31:0] a32, b32, s32;  logic c32, co32;

  ling_sparse_adder #(.W(16)) dut_i   (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
  ling_sparse_adder #(.W(8))  dut_w8  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
  ling_sparse_adder #(.W(32)) dut_w32 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run16(input logic [15:0] x, input logic [15:0] y, input logic ci, input string req);
    logic [16:0] e;
    a16 = x; b16 = y; c16 = ci;
    #5;
    e = {1'b0, x} + {1'b0, y} + {16'd0, ci};
    check(req, {16'd0, co16, s16}, {16'd0, e});
  endtask

  task automatic run32(input logic [31:0] x, input logic [31:0] y, input logic ci, input string req);
    logic [32:0] e;
    a32 = x; b32 = y; c32 = ci;
    #5;
    e = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    check(req, {co32, s32}, e);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    a16 = '0; b16 = '0; c16 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    #5;
    // R4: all-zero inputs give zero outputs
    check("R4 reset-state", {16'd0, co16, s16}, 33'd0);

    // R7 R1 R2: exhaustive sweep at W=8
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        for (int c = 0; c < 2; c++) begin
          logic [8:0] e;
          a8 = i[7:0]; b8 = j[7:0]; c8 = c[0];
          #1;
          e = {1'b0, i[7:0]} + {1'b0, j[7:0]} + {8'd0, c[0]};
          check("R7 R1 R2 w8", {24'd0, co8, s8}, {24'd0, e});
        end

    // R3: full propagation with cin
    run16(16'hFFFF, 16'h0000, 1'b1, "R3");
    check("R3 exact", {16'd0, co16, s16}, {16'd0, 1'b1, 16'h0000});
    run32(32'hFFFF_FFFF, 32'h0, 1'b1, "R3 w32");
    // R4: zero second operand
    run16(16'h9C3B, 16'h0000, 1'b0, "R4");
    check("R4 exact", {16'd0, co16, s16}, {16'd0, 1'b0, 16'h9C3B});
    // R5: top bits clear
    run16(16'h7FFF, 16'h7FFF, 1'b1, "R5");
    check("R5 exact", {32'd0, co16}, 33'd0);
    // R6: both all ones
    run16(16'hFFFF, 16'hFFFF, 1'b0, "R6");
    check("R6 cin0", {16'd0, co16, s16}, {16'd0, 1'b1, 16'hFFFE});
    run16(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    check("R6 cin1", {16'd0, co16, s16}, {16'd0, 1'b1, 16'hFFFF});
    // R8: alternating patterns
    run16(16'h5555, 16'hAAAA, 1'b0, "R8");
    check("R8 cin0", {16'd0, co16, s16}, {16'd0, 1'b0, 16'hFFFF});
    run16(16'h5555, 16'hAAAA, 1'b1, "R8");
    check("R8 cin1", {16'd0, co16, s16}, {16'd0, 1'b1, 16'h0000});
    run16(16'hAAAA, 16'hAAAA, 1'b1, "R8 R1");
    run32(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R8 w32");
    run32(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 w32");

    // R1 R2 R7: random vectors at W=16 and W=32
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      run16(x[15:0], y[15:0], x[31], "R1 R2 rand16");
      run32(x, y, y[0], "R1 R2 R7 rand32");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule